// File: doc/BRIEF.md
# Watchdog Start and Two-Step Refresh Controller

This block starts a watchdog timer and refreshes it in response to writes on a microcontroller special-function-register (SFR) bus. Software controls it through one flag bit in each of two byte-wide registers. The arm flag sits at bit 6 of address 0xA8. The start/refresh flag sits at bit 6 of address 0xB8. Each flag clears itself a fixed number of clocks after software sets it. Software can read a flag while it waits to clear.

When the watchdog is idle, setting the start/refresh flag starts it. When the watchdog is running, setting the start/refresh flag reloads the timeout counter only if the write that set it is the very next SFR write after the write that set the arm flag. A single stray write therefore cannot keep a runaway program alive. Once the watchdog runs, software cannot stop it. The counter loses one count on each prescaled tick. When it runs out, the block raises a one-clock reset request and returns to idle. The other bits of both registers are plain read/write storage.

Top module: `wdog_refresh_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, the watchdog is idle and the reset request is low.
- R2: Writing a byte with bit 6 = 1 to address 0xA8 sets the arm flag. The flag reads as 1 for exactly 12 clocks counted from the write edge and then clears by itself. Writing bit 6 = 0 does not clear it.
- R3: Writing a byte with bit 6 = 1 to address 0xB8 sets the start/refresh flag. This flag also reads as 1 for exactly 12 clocks and then clears by itself.
- R4: Setting the start/refresh flag while the watchdog is idle starts it and loads the counter with TIMEOUT.
- R5: While the watchdog runs, the counter reloads (and the prescaler restarts) only when the start/refresh flag is set by the SFR write directly after the write that set the arm flag, and while the arm flag is still set. Once the arm flag has self-cleared, the start/refresh write does not reload the counter.
- R6: Setting the start/refresh flag alone while the watchdog runs does not reload the counter.
- R7: Any other SFR write, to any address, between the arm write and the start/refresh write cancels the refresh.
- R8: TIMEOUT×PRESCALE clocks after the last start or reload edge, the reset request goes high for exactly one clock and the watchdog returns to idle.
- R9: No register write can stop a running watchdog.
- R10: All register bits other than bit 6 store the written value. Writing them does not restart or cancel the timer of a flag that is pending.
- R11: A read of 0xA8 or 0xB8 returns the stored bits with the live flag in bit 6. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | Write strobe, one write per clock where high |
| sfr_rdata | output | 8 | Combinational read data for sfr_addr |
| wd_running | output | 1 | Watchdog is counting |
| rst_req | output | 1 | One-clock reset request on expiry |

## Verification
The assertions check these properties on every cycle:
- the reset request lasts a single clock and coincides with the return to idle;
- a running watchdog never leaves the running state except at expiry;
- every start or reload leaves the counter at TIMEOUT;
- no flag stays high longer than its clear delay.

Some behaviour depends on the order of whole write sequences, and only the bench scenarios can show it:
- whether a refresh happens at all when the arm write is adjacent, separated by another write, or already expired;
- the exact expiry cycle that follows from the counter reload.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;

  // Remove the self-clearing flag position from a written byte.
  function automatic logic [7:0] strip_flag(input logic [7:0] d, input int unsigned pos);
    return d & ~(8'(1) << pos);
  endfunction

  // Rebuild the readable byte from stored bits and the live flag.
  function automatic logic [7:0] merge_flag(input logic [7:0] store, input logic flag,
                                            input int unsigned pos);
    return store | (8'(flag) << pos);
  endfunction

endpackage

// File: rtl/wdr_flag_timer.sv
module wdr_flag_timer #(
  parameter int unsigned CLR_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  localparam int unsigned CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      left_q <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      left_q <= CNT_W'(CLR_CYCLES - 1);
    end else if (flag_o) begin
      if (left_q == '0) flag_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdr_seq_detect.sv
module wdr_seq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic arm_wr_i,
  input  logic arm_flag_i,
  output logic armed_o
);
  logic last_was_arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_was_arm_q <= 1'b0;
    else if (wr_i) last_was_arm_q <= arm_wr_i;
  end

  assign armed_o = last_was_arm_q & arm_flag_i;
endmodule

// File: rtl/wdr_timeout.sv
module wdr_timeout
  import wdr_pkg::*;
#(
  parameter int unsigned TIMEOUT  = 8,
  parameter int unsigned PRESCALE = 4,
  localparam int unsigned CW = $clog2(TIMEOUT + 1),
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  output logic          running_o,
  output logic          expire_evt_o,
  output logic          expire_o,
  output logic [CW-1:0] count_o
);
  wd_state_e     state_q;
  logic [PW-1:0] pre_q;
  logic          tick;

  assign running_o    = (state_q == WD_RUN);
  assign tick         = running_o && (pre_q == PW'(PRESCALE - 1));
  assign expire_evt_o = tick && (count_o == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= WD_IDLE;
      pre_q    <= '0;
      count_o  <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (load_i) begin
        state_q <= WD_RUN;
        count_o <= CW'(TIMEOUT);
        pre_q   <= '0;
      end else if (running_o) begin
        if (tick) begin
          pre_q <= '0;
          if (expire_evt_o) begin
            expire_o <= 1'b1;
            state_q  <= WD_IDLE;
            count_o  <= '0;
          end else begin
            count_o <= count_o - 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_refresh_ctrl.sv
module wdog_refresh_ctrl
  import wdr_pkg::*;
#(
  parameter logic [7:0]  ARM_ADDR   = 8'hA8,
  parameter logic [7:0]  TRIG_ADDR  = 8'hB8,
  parameter int unsigned FLAG_BIT   = 6,
  parameter int unsigned CLR_CYCLES = 12,
  parameter int unsigned TIMEOUT    = 8,
  parameter int unsigned PRESCALE   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_we,
  output logic [7:0] sfr_rdata,
  output logic       wd_running,
  output logic       rst_req
);
  localparam int unsigned NREG = 2;
  localparam int unsigned CW   = $clog2(TIMEOUT + 1);
  localparam logic [8*NREG-1:0] ADDR_VEC = {TRIG_ADDR, ARM_ADDR};

  logic [NREG-1:0] hit, flag_set, flags;
  logic [7:0]      store_q [NREG];
  logic            armed, start_evt, refresh_evt, load, expire_evt;
  logic [CW-1:0]   wd_count;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i]      = sfr_we && (sfr_addr == ADDR_VEC[i*8 +: 8]);
    assign flag_set[i] = hit[i] && sfr_wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
      if (!rst_n)      store_q[i] <= '0;
      else if (hit[i]) store_q[i] <= strip_flag(sfr_wdata, FLAG_BIT);
    end

    wdr_flag_timer #(.CLR_CYCLES(CLR_CYCLES)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[i]),
      .flag_o (flags[i])
    );
  end

  always_comb begin
    sfr_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sfr_addr == ADDR_VEC[i*8 +: 8]) sfr_rdata = merge_flag(store_q[i], flags[i], FLAG_BIT);
    end
  end

  wdr_seq_detect u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (sfr_we),
    .arm_wr_i   (flag_set[0]),
    .arm_flag_i (flags[0]),
    .armed_o    (armed)
  );

  assign start_evt   = flag_set[1] && !wd_running;
  assign refresh_evt = flag_set[1] && wd_running && armed;
  assign load        = start_evt || refresh_evt;

  wdr_timeout #(.TIMEOUT(TIMEOUT), .PRESCALE(PRESCALE)) u_tmo (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .running_o    (wd_running),
    .expire_evt_o (expire_evt),
    .expire_o     (rst_req),
    .count_o      (wd_count)
  );
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
  parameter int unsigned CLR_CYCLES = 12,
  parameter int unsigned TIMEOUT    = 8,
  localparam int unsigned CW = $clog2(TIMEOUT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          wd_running,
  input logic          expire_evt,
  input logic          start_evt,
  input logic          refresh_evt,
  input logic [CW-1:0] wd_count,
  input logic          arm_set,
  input logic          arm_flag,
  input logic          trig_set,
  input logic          trig_flag
);
  int unsigned arm_age, trig_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_age  <= 0;
      trig_age <= 0;
    end else begin
      arm_age  <= arm_set  ? 1 : (arm_flag  ? arm_age + 1  : 0);
      trig_age <= trig_set ? 1 : (trig_flag ? trig_age + 1 : 0);
    end
  end

  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_idle_on_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !wd_running);
  p_no_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_running && !expire_evt) |=> wd_running);
  p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (wd_running && wd_count == CW'(TIMEOUT)));
  p_refresh_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_evt |=> (wd_count == CW'(TIMEOUT)));
  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_set |=> arm_flag);
  p_arm_life_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_flag |-> (arm_age <= CLR_CYCLES));
  p_trig_life_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flag |-> (trig_age <= CLR_CYCLES));
endmodule

bind wdog_refresh_ctrl wdr_checker #(.CLR_CYCLES(CLR_CYCLES), .TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_req     (rst_req),
  .wd_running  (wd_running),
  .expire_evt  (expire_evt),
  .start_evt   (start_evt),
  .refresh_evt (refresh_evt),
  .wd_count    (wd_count),
  .arm_set     (flag_set[0]),
  .arm_flag    (flags[0]),
  .trig_set    (flag_set[1]),
  .trig_flag   (flags[1])
);

// File: tb/wdog_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdog_refresh_ctrl_tb_top;
  localparam int CLR = 12;
  localparam int WIN = 8 * 4;   // TIMEOUT * PRESCALE
  localparam logic [7:0] A_ARM  = 8'hA8;
  localparam logic [7:0] A_TRIG = 8'hB8;

  logic       clk = 0, rst_n = 0, sfr_we = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0;
  logic [7:0] sfr_rdata;
  logic       wd_running, rst_req;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_q[$];          // scoreboard of expected expiry cycles
  bit last_arm = 0;
  int arm_edge = -100;
  bit prev_rst = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_refresh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .wd_running(wd_running), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: one SFR write; returns the edge index; updates the expiry model.
  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e);
    bit running, refresh;
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    @(negedge clk);
    e = cyc; sfr_we = 0; sfr_addr = 8'h00;
    if (a == A_TRIG && d[6]) begin
      running = (exp_q.size() > 0) && (exp_q[$] > e);
      refresh = running && last_arm && (e - arm_edge < CLR);
      if (!running) exp_q.push_back(e + WIN);
      else if (refresh) begin void'(exp_q.pop_back()); exp_q.push_back(e + WIN); end
    end
    last_arm = (a == A_ARM && d[6]);
    if (last_arm) arm_edge = e;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    sfr_addr = a; #1;
    check(req, sfr_rdata, exp);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as reset requests appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) begin
        if (exp_q.size() == 0) check("R8 unexpected rst_req", cyc, -1);
        else check("R8 expiry cycle", cyc, exp_q.pop_front());
        check("R8 pulse width", int'(prev_rst), 0);
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        check("R8 missing rst_req", cyc, exp_q.pop_front());
      end
      prev_rst = rst_req;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e, e2, s, t, a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(A_ARM, 8'h00, "R1 arm reg");
    rd(A_TRIG, 8'h00, "R1 trig reg");
    check("R1 running", wd_running, 0);
    check("R1 rst_req", rst_req, 0);
    // R10 / R11 storage and decode
    wr(A_ARM, 8'h85, e);  rd(A_ARM, 8'h85, "R10 arm storage");
    wr(A_TRIG, 8'h3F, e); rd(A_TRIG, 8'h3F, "R10 trig storage");
    rd(8'h30, 8'h00, "R11 other address");
    check("R10 no start on bit6=0", wd_running, 0);
    // R2 arm flag lifetime, R10 plain write mid-way
    wr(A_ARM, 8'hC5, e);  rd(A_ARM, 8'hC5, "R2 arm set");
    wait_to(e + 4);
    wr(A_ARM, 8'h81, e2); rd(A_ARM, 8'hC1, "R10 flag kept, bits stored");
    wait_to(e + CLR - 1); rd(A_ARM, 8'hC1, "R2 arm still set at 11");
    wait_to(e + CLR);     rd(A_ARM, 8'h81, "R2 arm cleared at 12");
    // R3 / R4 start, R6 lone trigger, R9 no stop
    wr(A_TRIG, 8'h40, s);
    rd(A_TRIG, 8'h40, "R3 trig set");
    check("R4 started", wd_running, 1);
    wait_to(s + CLR - 1); rd(A_TRIG, 8'h40, "R3 trig still set at 11");
    wait_to(s + CLR);     rd(A_TRIG, 8'h00, "R3 trig cleared at 12");
    wr(A_TRIG, 8'h40, e);                      // R6: no reload expected
    wr(A_ARM, 8'h00, e); wr(A_TRIG, 8'h00, e); // R9
    check("R9 still running", wd_running, 1);
    wait_to(s + WIN - 1); check("R6 running before expiry", wd_running, 1);
    wait_to(s + WIN + 1); check("R8 idle after expiry", wd_running, 0);
    // R5 valid refresh
    wr(A_TRIG, 8'h40, s);
    wait_to(s + 20);
    wr(A_ARM, 8'h40, a); wr(A_TRIG, 8'h40, t);
    wait_to(s + WIN + 1); check("R5 refreshed still running", wd_running, 1);
    wait_to(t + WIN + 1); check("R5 expiry after refresh", wd_running, 0);
    // R7 intervening write cancels
    wr(A_TRIG, 8'h40, s);
    wr(A_ARM, 8'h40, a); wr(8'h30, 8'h55, e); wr(A_TRIG, 8'h40, t);
    wait_to(s + WIN + 1); check("R7 no refresh", wd_running, 0);
    // R5 stale arm flag
    wr(A_TRIG, 8'h40, s);
    wr(A_ARM, 8'h40, a);
    wait_to(a + CLR + 1);
    wr(A_TRIG, 8'h40, t);
    wait_to(s + WIN + 1); check("R5 stale arm no refresh", wd_running, 0);
    wait_to(cyc + 4);
    check("R8 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule